// File: doc/BRIEF.md
# Interrupt Trigger Front End

This block sits in front of a pair of eight-input interrupt controllers. It turns assert, deassert and pulse events on sixteen interrupt pins into single-cycle request-set and request-clear strobes for the controllers' request latches. Each pin can be programmed as edge-triggered or level-triggered. The selection is held in a trigger register that is written and read one byte per controller. Some pins can never be made level-triggered, because a fixed mask is applied to every write.

More than one source may drive the same pin, so the pins behave as a wired OR. Each pin keeps a small saturating count of the sources that currently assert it. A request is raised on the first assertion. It is held for as long as any source asserts a level-triggered pin. It is withdrawn only when the last source of a level-triggered pin lets go. Events addressed to a controller that has not finished initialization are discarded. A deassert on a pin whose count is already zero sets a sticky error flag.

One event is accepted per cycle on `evt_valid`/`evt_pin`/`evt_op`. Its strobes appear one clock later. An event sees the trigger selection that was in force before any write in the same cycle.

Top module: `irq_trigger_front`

## Requirements
- R1: `evt_op` encodes 0 = assert, 1 = deassert, 2 = pulse and 3 = no operation. An assert adds one to the pin's count and a deassert removes one. A deassert that leaves the count above zero raises `req_set` for that pin only when the pin is level-triggered.
- R2: An assert on a pin whose count is zero raises bit `evt_pin` of `req_set` in the cycle after the event, in both trigger modes.
- R3: An assert on a pin whose count is already above zero raises `req_set` when the pin is level-triggered, and produces no strobe when the pin is edge-triggered.
- R4: A deassert that takes the count from one to zero raises `req_clr` for a level-triggered pin. For an edge-triggered pin it produces no strobe.
- R5: A pulse leaves the count unchanged. With a count of zero it gives `req_set` on an edge pin and `req_clr` on a level pin. With a count above zero it gives `req_set` on a level pin and nothing on an edge pin.
- R6: Bit b of trigger byte c selects level mode (1) or edge mode (0) for pin 8c+b. Writes to byte 0 are ANDed with 0xF8 and writes to byte 1 with 0xDE, so pins 0, 1, 2, 8 and 13 always read back as edge. Both bytes reset to zero, and a byte changes only when it is written.
- R7: An event on a pin whose controller has its `ctl_ready` bit low, or an event with op code 3, changes no count, produces no strobe and sets no error.
- R8: A deassert on a pin whose count is zero keeps the count at zero and produces no strobe. It sets `err_underflow` one cycle later, and the flag stays set until reset.
- R9: The count saturates at 7. An assert at 7 keeps it at 7, so seven deasserts then return the pin to zero. The strobe of an assert at 7 follows R3.
- R10: At most one bit across `req_set` and `req_clr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_ready | input | 2 | Per-controller initialization-complete flags |
| evt_valid | input | 1 | Event present this cycle |
| evt_pin | input | 4 | Target pin; bit 3 selects the controller |
| evt_op | input | 2 | Event type (0 assert, 1 deassert, 2 pulse, 3 none) |
| trig_wr_en | input | 1 | Trigger byte write strobe |
| trig_wr_sel | input | 1 | Trigger byte selected for write |
| trig_wr_data | input | 8 | Trigger byte write data before masking |
| trig_rd_sel | input | 1 | Trigger byte selected for read |
| trig_rd_data | output | 8 | Selected trigger byte (combinational) |
| req_set | output | 16 | Per-pin request-set strobe |
| req_clr | output | 16 | Per-pin request-clear strobe |
| err_underflow | output | 1 | Sticky count-underflow flag |

## Verification
Assertions check several properties on every cycle. No more than one strobe is active at a time. A clear strobe follows only a level-mode pin. The first assert from zero always sets. Idle or discarded events leave every count and strobe quiet. A count moves by at most one per event. A trigger byte holds its value unless it is written. The underflow flag never drops. The exact strobe chosen for each combination of count, mode and event type can only be shown by the bench's scenarios. These scenarios walk every pin up to saturation and back down under three trigger patterns. They also sweep all 256 write values into both trigger bytes, which shows the fixed masks at the ports.

// File: rtl/irqtf_pkg.sv
package irqtf_pkg;

  localparam int CNT_MAX_W = 8;

  typedef logic [CNT_MAX_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    OP_ASSERT   = 2'd0,
    OP_DEASSERT = 2'd1,
    OP_PULSE    = 2'd2,
    OP_NONE     = 2'd3
  } pin_op_e;

  typedef struct packed {
    cnt_t nxt;
    logic set;
    logic clr;
    logic uflow;
  } pin_res_t;

  // Highest count representable in w bits
  function automatic cnt_t cnt_ceiling(int unsigned w);
    return cnt_t'((1 << w) - 1);
  endfunction

  // Effect of one event on a pin: next count and the strobe it produces
  function automatic pin_res_t pin_step(pin_op_e op, cnt_t cnt, cnt_t ceil, logic lvl);
    pin_res_t r;
    r.nxt   = cnt;
    r.set   = 1'b0;
    r.clr   = 1'b0;
    r.uflow = 1'b0;
    unique case (op)
      OP_ASSERT: begin
        if (cnt < ceil) r.nxt = cnt + cnt_t'(1);
        r.set = (cnt == '0) | lvl;
      end
      OP_DEASSERT: begin
        if (cnt == '0) begin
          r.uflow = 1'b1;
        end else begin
          r.nxt = cnt - cnt_t'(1);
          if (cnt == cnt_t'(1)) r.clr = lvl;
          else                  r.set = lvl;
        end
      end
      OP_PULSE: begin
        if (cnt == '0) begin
          r.set = ~lvl;
          r.clr = lvl;
        end else begin
          r.set = lvl;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irqtf_trig_reg.sv
module irqtf_trig_reg #(
  parameter int NUM_CTL  = 2,
  parameter int PINS_PER = 8,
  localparam int NPINS   = NUM_CTL * PINS_PER,
  localparam int CTL_W   = (NUM_CTL > 1) ? $clog2(NUM_CTL) : 1,
  parameter logic [NPINS-1:0] LEVEL_OK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTL_W-1:0]    wr_sel,
  input  logic [PINS_PER-1:0] wr_data,
  input  logic [CTL_W-1:0]    rd_sel,
  output logic [PINS_PER-1:0] rd_data,
  output logic [NPINS-1:0]    lvl
);

  logic [NPINS-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_CTL; k++) begin
        if (wr_sel == CTL_W'(k))
          lvl_q[k*PINS_PER +: PINS_PER] <= wr_data & LEVEL_OK[k*PINS_PER +: PINS_PER];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CTL; k++) begin
      if (rd_sel == CTL_W'(k)) rd_data = lvl_q[k*PINS_PER +: PINS_PER];
    end
  end

  assign lvl = lvl_q;

  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lvl_q)); // R6

endmodule

// File: rtl/irqtf_event_decode.sv
module irqtf_event_decode import irqtf_pkg::*; #(
  parameter int NUM_CTL  = 2,
  parameter int PINS_PER = 8,
  localparam int NPINS   = NUM_CTL * PINS_PER,
  localparam int PIN_W   = $clog2(NPINS)
) (
  input  logic               evt_valid,
  input  logic [PIN_W-1:0]   evt_pin,
  input  logic [1:0]         evt_op,
  input  logic [NUM_CTL-1:0] ctl_ready,
  output logic [NPINS-1:0]   hit,
  output pin_op_e            op
);

  assign op = pin_op_e'(evt_op);

  for (genvar i = 0; i < NPINS; i++) begin : g_hit
    assign hit[i] = evt_valid && (evt_pin == PIN_W'(i)) &&
                    ctl_ready[i / PINS_PER] && (op != OP_NONE);
  end

endmodule

// File: rtl/irqtf_pin_cell.sv
module irqtf_pin_cell import irqtf_pkg::*; #(
  parameter int CNT_W = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hit,
  input  pin_op_e op,
  input  logic    lvl,
  output logic    set_q,
  output logic    clr_q,
  output logic    uflow
);

  localparam cnt_t CEIL = cnt_ceiling(CNT_W);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_q;
  pin_res_t         res;

  always_comb res = pin_step(op, cnt_t'(cnt_q), CEIL, lvl);

  if (CNT_W < CNT_MAX_W) begin : g_spare
    logic spare_unused;
    assign spare_unused = ^res.nxt[CNT_MAX_W-1:CNT_W];
  end

  assign uflow = hit & res.uflow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      set_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      set_q <= hit & res.set;
      clr_q <= hit & res.clr;
      if (hit) cnt_q <= res.nxt[CNT_W-1:0];
    end
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_ASSERT && cnt_q == '0) |=> (set_q && cnt_q == CNT_W'(1))); // R2

  AST_CLR_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(lvl)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!set_q && !clr_q && $stable(cnt_q))); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} == {1'b0, $past(cnt_q)}) ||
    ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + ONE) ||
    ({1'b0, cnt_q} + ONE == {1'b0, $past(cnt_q)})); // R1

  AST_UFLOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (cnt_q == '0 && !set_q && !clr_q)); // R8

endmodule

// File: rtl/irq_trigger_front.sv
module irq_trigger_front import irqtf_pkg::*; #(
  parameter int NUM_CTL  = 2,
  parameter int PINS_PER = 8,
  parameter int CNT_W    = 3,
  localparam int NPINS   = NUM_CTL * PINS_PER,
  localparam int PIN_W   = $clog2(NPINS),
  localparam int CTL_W   = (NUM_CTL > 1) ? $clog2(NUM_CTL) : 1,
  parameter logic [NPINS-1:0] LEVEL_OK = 16'hDEF8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CTL-1:0]  ctl_ready,
  input  logic                evt_valid,
  input  logic [PIN_W-1:0]    evt_pin,
  input  logic [1:0]          evt_op,
  input  logic                trig_wr_en,
  input  logic [CTL_W-1:0]    trig_wr_sel,
  input  logic [PINS_PER-1:0] trig_wr_data,
  input  logic [CTL_W-1:0]    trig_rd_sel,
  output logic [PINS_PER-1:0] trig_rd_data,
  output logic [NPINS-1:0]    req_set,
  output logic [NPINS-1:0]    req_clr,
  output logic                err_underflow
);

  logic [NPINS-1:0] lvl_vec;
  logic [NPINS-1:0] hit_vec;
  logic [NPINS-1:0] uflow_vec;
  pin_op_e          op_dec;
  logic             err_q;

  irqtf_trig_reg #(
    .NUM_CTL (NUM_CTL),
    .PINS_PER(PINS_PER),
    .LEVEL_OK(LEVEL_OK)
  ) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (trig_wr_en),
    .wr_sel (trig_wr_sel),
    .wr_data(trig_wr_data),
    .rd_sel (trig_rd_sel),
    .rd_data(trig_rd_data),
    .lvl    (lvl_vec)
  );

  irqtf_event_decode #(
    .NUM_CTL (NUM_CTL),
    .PINS_PER(PINS_PER)
  ) u_dec (
    .evt_valid(evt_valid),
    .evt_pin  (evt_pin),
    .evt_op   (evt_op),
    .ctl_ready(ctl_ready),
    .hit      (hit_vec),
    .op       (op_dec)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    irqtf_pin_cell #(.CNT_W(CNT_W)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (hit_vec[i]),
      .op   (op_dec),
      .lvl  (lvl_vec[i]),
      .set_q(req_set[i]),
      .clr_q(req_clr[i]),
      .uflow(uflow_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|uflow_vec);
  end

  assign err_underflow = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_set | req_clr)); // R10

endmodule

// File: tb/sim_irq_trigger_front.sv
module sim_irq_trigger_front;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ctl_ready;
  logic        evt_valid;
  logic [3:0]  evt_pin;
  logic [1:0]  evt_op;
  logic        trig_wr_en;
  logic        trig_wr_sel;
  logic [7:0]  trig_wr_data;
  logic        trig_rd_sel;
  logic [7:0]  trig_rd_data;
  logic [15:0] req_set;
  logic [15:0] req_clr;
  logic        err_underflow;

  always #2 clk = ~clk;

  irq_trigger_front u0 (
    .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready),
    .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_op(evt_op),
    .trig_wr_en(trig_wr_en), .trig_wr_sel(trig_wr_sel), .trig_wr_data(trig_wr_data),
    .trig_rd_sel(trig_rd_sel), .trig_rd_data(trig_rd_data),
    .req_set(req_set), .req_clr(req_clr), .err_underflow(err_underflow)
  );

  int          vecs = 0;
  int          miss = 0;
  int          cnt_m [16];
  logic [15:0] lvl_m = '0;
  logic        err_m = 1'b0;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // R6: model of the fixed write masks
  function automatic logic [7:0] masked(int sel, logic [7:0] d);
    return (sel == 0) ? (d & 8'hF8) : (d & 8'hDE);
  endfunction

  task automatic trig_write(int sel, logic [7:0] d);
    @(negedge clk);
    trig_wr_en   = 1'b1;
    trig_wr_sel  = sel[0];
    trig_wr_data = d;
    @(negedge clk);
    trig_wr_en  = 1'b0;
    trig_rd_sel = sel[0];
    lvl_m[sel*8 +: 8] = masked(sel, d);
    #1;
    check("R6", "trigger readback", {8'h00, trig_rd_data}, {8'h00, masked(sel, d)});
  endtask

  task automatic send(int pin, int op);
    logic [15:0] es = '0;
    logic [15:0] ec = '0;
    string tag;
    int  c   = cnt_m[pin];
    logic lv = lvl_m[pin];
    logic rdy = ctl_ready[pin / 8];
    if (!rdy || op == 3) begin
      tag = "R7";
    end else if (op == 0) begin
      tag = (c == 7) ? "R9" : ((c == 0) ? "R2" : "R3");
      if (c == 0 || lv) es[pin] = 1'b1;
      if (c < 7) c = c + 1;
    end else if (op == 1) begin
      if (c == 0) begin
        tag = "R8";
        err_m = 1'b1;
      end else begin
        tag = (c == 1) ? "R4" : "R1";
        if (c == 1) ec[pin] = lv;
        else        es[pin] = lv;
        c = c - 1;
      end
    end else begin
      tag = "R5";
      if (c == 0) begin
        if (lv) ec[pin] = 1'b1;
        else    es[pin] = 1'b1;
      end else begin
        es[pin] = lv;
      end
    end
    cnt_m[pin] = c;
    @(negedge clk);
    evt_valid = 1'b1;
    evt_pin   = pin[3:0];
    evt_op    = op[1:0];
    @(negedge clk);
    evt_valid = 1'b0;
    check(tag, "req_set", req_set, es);
    check(tag, "req_clr", req_clr, ec);
    check(tag, "err_underflow", {15'd0, err_underflow}, {15'd0, err_m});
    check("R10", "strobe count", 16'($countones(req_set | req_clr)) <= 16'd1 ? 16'd1 : 16'd0, 16'd1);
  endtask

  task automatic pin_walk(int pin);
    for (int n = 0; n < 8; n++) send(pin, 0);
    send(pin, 2);
    for (int n = 0; n < 7; n++) send(pin, 1);
    send(pin, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int p = 0; p < 16; p++) cnt_m[p] = 0;
    rst_n = 1'b0; ctl_ready = 2'b00; evt_valid = 1'b0; evt_pin = '0; evt_op = '0;
    trig_wr_en = 1'b0; trig_wr_sel = 1'b0; trig_wr_data = '0; trig_rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2", "reset req_set", req_set, 16'h0);
    check("R4", "reset req_clr", req_clr, 16'h0);
    check("R8", "reset err_underflow", {15'd0, err_underflow}, 16'h0);
    check("R6", "reset trigger byte 0", {8'h00, trig_rd_data}, 16'h0);
    trig_rd_sel = 1'b1;
    #1;
    check("R6", "reset trigger byte 1", {8'h00, trig_rd_data}, 16'h0);

    // R6: every write value into both bytes
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 256; d++) trig_write(s, d[7:0]);
    trig_write(0, 8'hFF);
    trig_write(1, 8'hFF);

    // R7: controllers not ready, and the no-op code
    for (int p = 0; p < 16; p++)
      for (int o = 0; o < 4; o++) send(p, o);
    ctl_ready = 2'b01;
    for (int p = 0; p < 16; p++) send(p, 3);
    for (int p = 8; p < 16; p++) send(p, 0);
    ctl_ready = 2'b10;
    for (int p = 0; p < 8; p++) send(p, 1);
    ctl_ready = 2'b11;

    // R1..R5, R9: walk each pin up to saturation and back, three trigger patterns
    for (int pass = 0; pass < 3; pass++) begin
      if (pass == 1) begin trig_write(0, 8'h00); trig_write(1, 8'h00); end
      if (pass == 2) begin trig_write(0, 8'h55); trig_write(1, 8'h55); end
      for (int p = 0; p < 16; p++) pin_walk(p);
    end

    // R3: shared line on a level pin, set on each extra assert
    trig_write(1, 8'hFF);
    send(14, 0); send(14, 0); send(14, 1); send(14, 1);

    // R8: underflow is sticky and harmless to the count
    send(5, 1);
    send(3, 0);
    send(3, 1);
    send(5, 0);
    send(5, 1);
    send(12, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule